// File: doc/BRIEF.md
# Page-Mapped Flash Translation Layer

This block sits between a host and a single NAND array port. The host sees a flat range of logical pages numbered from zero, and it reads, writes or trims them one page at a time. Internally each logical page maps to any physical page. A write always lands on a freshly erased page at the current write pointer. The map is then redirected, and the page that held the data before is only marked dead. Nothing is ever erased and rewritten in place.

Dead pages pile up inside blocks. When the pool of erased blocks shrinks to a set floor, the block stops taking host commands and runs a collection pass. The pass picks the written block that holds the fewest live pages, moves those pages to the write pointer one by one, and erases the block. The physical array holds more blocks than the logical range needs, so a victim with at least one dead page always exists. Two running counts, of host page writes and of all page programs, let the host measure write amplification.

Top module: `ftl_top`

## Requirements
- R1: The host addresses logical pages 0 to LPAGES-1 with host_op 0 = read, 1 = write and 2 = trim; code 3 is ignored. A read of a written page returns the data from the last write to that page.
- R2: Every program command targets a physical page that has not been programmed since its last erase. A rewrite of a logical page lands on a physical page other than the one that held its previous copy.
- R3: A superseded copy is dead: a victim block whose pages are all superseded is erased with no page copied out of it.
- R4: A read of a logical page that was never written, or was trimmed, returns all ones with rsp_valid one cycle after acceptance, and issues no NAND command.
- R5: Trimming a page kills its physical copy, so a later collection does not copy it.
- R6: When the count of erased blocks falls to GC_THRESH or below, host_ready stays low until a victim is erased. The victim is the written, non-active block with the fewest live pages, with the lowest block number winning a tie.
- R7: Collection reads each live page of the victim and programs its data at the write pointer, with data preserved, before it erases the victim.
- R8: After reset block 0 is the write block and all other blocks are free. Pages fill in ascending order within a block, and a full write block is replaced by the lowest-numbered free block. A physical page address is {block, page}.
- R9: host_wr_cnt counts completed host page writes; phys_wr_cnt counts every completed program, including collection copies.
- R10: NAND commands are one-cycle pulses with nand_op 0 = read, 1 = program and 2 = erase. Only one command is outstanding until nand_done. An erase carries page bits of zero.
- R11: After reset host_ready is high, both counters are zero and no NAND command is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_valid | input | 1 | Host command present |
| host_op | input | 2 | 0 read, 1 write, 2 trim |
| host_lpa | input | LPA_W | Logical page number |
| host_wdata | input | DATA_W | Write data |
| host_ready | output | 1 | Command accepted this cycle when high with host_valid |
| rsp_valid | output | 1 | Read data valid pulse |
| rsp_data | output | DATA_W | Read data |
| nand_cmd_valid | output | 1 | NAND command pulse |
| nand_op | output | 2 | 0 read, 1 program, 2 erase |
| nand_ppa | output | PPA_W | Physical page address {block, page} |
| nand_wdata | output | DATA_W | Program data |
| nand_done | input | 1 | Command completion pulse |
| nand_rdata | input | DATA_W | Read data, valid with nand_done |
| host_wr_cnt | output | CNT_W | Completed host page writes |
| phys_wr_cnt | output | CNT_W | Completed page programs of any origin |

## Verification
The hardest case to reach from the ports is a collection whose victim is known in advance and whose number of copies is known. That needs a specific pattern of live and dead pages across full blocks at the moment the free pool hits the floor. The stimulus starts from the deterministic allocation order and writes a planned sequence of logical pages. This leaves one block fully superseded and later a block with a single live page after a trim. The erase address and the difference between the two counters then pin down the victim and the copy count. A long random mix of writes, reads and trims follows, driving many further collections, and a bench flash model checks every program target and every read-back.

// File: rtl/ftl_pkg.sv
// Shared encodings for the flash translation layer.
// Assumes two-bit opcode fields on both the host and the NAND side.
package ftl_pkg;
    typedef enum logic [1:0] {HOP_READ = 2'd0, HOP_WRITE = 2'd1, HOP_TRIM = 2'd2} host_op_e;
    typedef enum logic [1:0] {NOP_READ = 2'd0, NOP_PROG = 2'd1, NOP_ERASE = 2'd2} nand_op_e;
    typedef enum logic [2:0] {
        S_IDLE, S_HRD, S_HWR, S_GC_SCAN, S_GC_STEP, S_GC_RD, S_GC_WR, S_GC_ERS
    } ftl_state_e;
endpackage

// File: rtl/ftl_l2p.sv
// Logical-to-physical map: one entry per logical page, with a mapped flag.
// Assumes at most one update per cycle; the lookup is combinational.
module ftl_l2p #(
    parameter int LPAGES = 16,
    parameter int PPA_W  = 5,
    localparam int LPA_W = $clog2(LPAGES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LPA_W-1:0] rd_lpa,
    output logic             rd_valid,
    output logic [PPA_W-1:0] rd_ppa,
    input  logic             wr_en,
    input  logic [LPA_W-1:0] wr_lpa,
    input  logic             wr_valid,
    input  logic [PPA_W-1:0] wr_ppa
);
    logic [LPAGES-1:0] mapped;
    logic [PPA_W-1:0]  loc [LPAGES];

    // Mapped flags: cleared on reset, set by a program, cleared by a trim.
    always_ff @(posedge clk) begin
        if (!rst_n)     mapped <= '0;
        else if (wr_en) mapped[wr_lpa] <= wr_valid;
    end

    // Physical locations: written alongside the flag; no reset needed.
    always_ff @(posedge clk) begin
        if (wr_en && wr_valid) loc[wr_lpa] <= wr_ppa;
    end

    assign rd_valid = mapped[rd_lpa];
    assign rd_ppa   = loc[rd_lpa];

    AST_MAP_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_valid && mapped[wr_lpa]) |-> (loc[wr_lpa] != wr_ppa)); // R2
endmodule

// File: rtl/ftl_ptable.sv
// Physical page table: a live flag and an owning logical page per physical page,
// per-block live counts, and the greedy victim search (fewest live, lowest index).
// Assumes PAGES is a power of two and a physical address is {block, page}.
module ftl_ptable #(
    parameter int BLOCKS = 8,
    parameter int PAGES  = 4,
    parameter int LPAGES = 16,
    localparam int NPPA  = BLOCKS * PAGES,
    localparam int PPA_W = $clog2(NPPA),
    localparam int BLK_W = $clog2(BLOCKS),
    localparam int LPA_W = $clog2(LPAGES),
    localparam int VC_W  = $clog2(PAGES + 2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_en,
    input  logic [PPA_W-1:0]  set_ppa,
    input  logic [LPA_W-1:0]  set_lpa,
    input  logic              clr_en,
    input  logic [PPA_W-1:0]  clr_ppa,
    input  logic [PPA_W-1:0]  q_ppa,
    output logic              q_valid,
    output logic [LPA_W-1:0]  q_lpa,
    input  logic [BLOCKS-1:0] excl,
    output logic [BLK_W-1:0]  victim,
    output logic              victim_ok,
    input  logic [BLK_W-1:0]  cnt_blk,
    output logic [VC_W-1:0]   cnt_val
);
    logic [NPPA-1:0]  live;
    logic [LPA_W-1:0] owner [NPPA];
    logic [VC_W-1:0]  bcnt  [BLOCKS];
    logic [VC_W-1:0]  best;

    // Live flags: a kill and a birth may land in one cycle on different pages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live <= '0;
        end else begin
            if (clr_en) live[clr_ppa] <= 1'b0;
            if (set_en) live[set_ppa] <= 1'b1;
        end
    end

    // Owner record: tells collection which logical page a copy belongs to.
    always_ff @(posedge clk) begin
        if (set_en) owner[set_ppa] <= set_lpa;
    end

    // Live count of each block.
    for (genvar b = 0; b < BLOCKS; b++) begin : g_cnt
        assign bcnt[b] = VC_W'($countones(live[b*PAGES +: PAGES]));
    end

    // Greedy victim: strict compare keeps the lowest index on a tie.
    always_comb begin
        best      = VC_W'(PAGES + 1);
        victim    = '0;
        victim_ok = 1'b0;
        for (int b = 0; b < BLOCKS; b++) begin
            if (!excl[b] && (bcnt[b] < best)) begin
                best      = bcnt[b];
                victim    = BLK_W'(b);
                victim_ok = 1'b1;
            end
        end
    end

    assign q_valid = live[q_ppa];
    assign q_lpa   = owner[q_ppa];
    assign cnt_val = bcnt[cnt_blk];

    AST_SET_FRESH: assert property (@(posedge clk) disable iff (!rst_n)
        set_en |-> !live[set_ppa]); // R2
    AST_CLR_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en |-> live[clr_ppa]); // R3
endmodule

// File: rtl/ftl_top.sv
// Page-mapped translation layer top: host command decode, write pointer and
// free-block pool, collection sequencer and NAND command issue.
// Assumes one NAND command at a time and LPAGES well below BLOCKS*PAGES.
module ftl_top #(
    parameter int BLOCKS    = 8,
    parameter int PAGES     = 4,
    parameter int LPAGES    = 16,
    parameter int DATA_W    = 8,
    parameter int GC_THRESH = 2,
    parameter int CNT_W     = 16,
    localparam int NPPA   = BLOCKS * PAGES,
    localparam int PPA_W  = $clog2(NPPA),
    localparam int LPA_W  = $clog2(LPAGES),
    localparam int BLK_W  = $clog2(BLOCKS),
    localparam int PG_W   = $clog2(PAGES),
    localparam int FREE_W = $clog2(BLOCKS + 1),
    localparam int VC_W   = $clog2(PAGES + 2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_valid,
    input  logic [1:0]        host_op,
    input  logic [LPA_W-1:0]  host_lpa,
    input  logic [DATA_W-1:0] host_wdata,
    output logic              host_ready,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data,
    output logic              nand_cmd_valid,
    output logic [1:0]        nand_op,
    output logic [PPA_W-1:0]  nand_ppa,
    output logic [DATA_W-1:0] nand_wdata,
    input  logic              nand_done,
    input  logic [DATA_W-1:0] nand_rdata,
    output logic [CNT_W-1:0]  host_wr_cnt,
    output logic [CNT_W-1:0]  phys_wr_cnt
);
    import ftl_pkg::*;

    localparam logic [PG_W-1:0] LAST_PG = PG_W'(PAGES - 1);

    ftl_state_e        state;
    logic [BLOCKS-1:0] free_mask;
    logic [BLK_W-1:0]  act_blk, nxt_blk, victim_q, victim;
    logic [PG_W-1:0]   act_pg, gc_pg;
    logic [LPA_W-1:0]  cur_lpa, pg_lpa;
    logic [PPA_W-1:0]  act_ppa, map_ppa, gc_ppa, clr_ppa;
    logic [FREE_W-1:0] free_cnt;
    logic [VC_W-1:0]   vic_cnt;
    logic              need_gc, accept, map_valid, pg_valid, victim_ok;
    logic              prog_done, trim_hit, wr_acc, clr_en;

    assign act_ppa   = {act_blk, act_pg};
    assign gc_ppa    = {victim_q, gc_pg};
    assign free_cnt  = FREE_W'($countones(free_mask));
    assign need_gc   = free_cnt <= FREE_W'(GC_THRESH);
    assign host_ready = (state == S_IDLE) && !need_gc;
    assign accept    = host_valid && host_ready;
    assign wr_acc    = accept && (host_op == HOP_WRITE);
    assign trim_hit  = accept && (host_op == HOP_TRIM) && map_valid;
    assign prog_done = nand_done && ((state == S_HWR) || (state == S_GC_WR));
    assign clr_en    = (wr_acc && map_valid) || trim_hit || ((state == S_GC_WR) && nand_done);
    assign clr_ppa   = (state == S_GC_WR) ? gc_ppa : map_ppa;

    // Lowest-numbered free block, the next write block.
    always_comb begin
        nxt_blk = '0;
        for (int b = BLOCKS - 1; b >= 0; b--) begin
            if (free_mask[b]) nxt_blk = BLK_W'(b);
        end
    end

    ftl_l2p #(.LPAGES(LPAGES), .PPA_W(PPA_W)) u_l2p (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_lpa   (host_lpa),
        .rd_valid (map_valid),
        .rd_ppa   (map_ppa),
        .wr_en    (prog_done || trim_hit),
        .wr_lpa   (prog_done ? cur_lpa : host_lpa),
        .wr_valid (prog_done),
        .wr_ppa   (act_ppa)
    );

    ftl_ptable #(.BLOCKS(BLOCKS), .PAGES(PAGES), .LPAGES(LPAGES)) u_ptable (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_en    (prog_done),
        .set_ppa   (act_ppa),
        .set_lpa   (cur_lpa),
        .clr_en    (clr_en),
        .clr_ppa   (clr_ppa),
        .q_ppa     (gc_ppa),
        .q_valid   (pg_valid),
        .q_lpa     (pg_lpa),
        .excl      (free_mask | (BLOCKS'(1) << act_blk)),
        .victim    (victim),
        .victim_ok (victim_ok),
        .cnt_blk   (victim_q),
        .cnt_val   (vic_cnt)
    );

    // Sequencer: host commands, write pointer, free pool, collection and counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state          <= S_IDLE;
            free_mask      <= {{(BLOCKS-1){1'b1}}, 1'b0};
            act_blk        <= '0;
            act_pg         <= '0;
            victim_q       <= '0;
            gc_pg          <= '0;
            cur_lpa        <= '0;
            nand_cmd_valid <= 1'b0;
            nand_op        <= '0;
            nand_ppa       <= '0;
            nand_wdata     <= '0;
            rsp_valid      <= 1'b0;
            rsp_data       <= '0;
            host_wr_cnt    <= '0;
            phys_wr_cnt    <= '0;
        end else begin
            nand_cmd_valid <= 1'b0;
            rsp_valid      <= 1'b0;
            if (prog_done) begin
                phys_wr_cnt <= phys_wr_cnt + 1'b1;
                if (act_pg == LAST_PG) begin
                    act_blk            <= nxt_blk;
                    act_pg             <= '0;
                    free_mask[nxt_blk] <= 1'b0;
                end else begin
                    act_pg <= act_pg + 1'b1;
                end
            end
            case (state)
                S_IDLE: begin
                    if (need_gc) begin
                        state <= S_GC_SCAN;
                    end else if (host_valid && host_op == HOP_READ) begin
                        if (map_valid) begin
                            nand_cmd_valid <= 1'b1;
                            nand_op        <= NOP_READ;
                            nand_ppa       <= map_ppa;
                            state          <= S_HRD;
                        end else begin
                            rsp_valid <= 1'b1;
                            rsp_data  <= '1;
                        end
                    end else if (host_valid && host_op == HOP_WRITE) begin
                        nand_cmd_valid <= 1'b1;
                        nand_op        <= NOP_PROG;
                        nand_ppa       <= act_ppa;
                        nand_wdata     <= host_wdata;
                        cur_lpa        <= host_lpa;
                        state          <= S_HWR;
                    end
                end
                S_HRD: if (nand_done) begin
                    rsp_valid <= 1'b1;
                    rsp_data  <= nand_rdata;
                    state     <= S_IDLE;
                end
                S_HWR: if (nand_done) begin
                    host_wr_cnt <= host_wr_cnt + 1'b1;
                    state       <= S_IDLE;
                end
                S_GC_SCAN: begin
                    victim_q <= victim;
                    gc_pg    <= '0;
                    state    <= S_GC_STEP;
                end
                S_GC_STEP: begin
                    if (pg_valid) begin
                        nand_cmd_valid <= 1'b1;
                        nand_op        <= NOP_READ;
                        nand_ppa       <= gc_ppa;
                        cur_lpa        <= pg_lpa;
                        state          <= S_GC_RD;
                    end else if (gc_pg == LAST_PG) begin
                        nand_cmd_valid <= 1'b1;
                        nand_op        <= NOP_ERASE;
                        nand_ppa       <= {victim_q, {PG_W{1'b0}}};
                        state          <= S_GC_ERS;
                    end else begin
                        gc_pg <= gc_pg + 1'b1;
                    end
                end
                S_GC_RD: if (nand_done) begin
                    nand_cmd_valid <= 1'b1;
                    nand_op        <= NOP_PROG;
                    nand_ppa       <= act_ppa;
                    nand_wdata     <= nand_rdata;
                    state          <= S_GC_WR;
                end
                S_GC_WR: if (nand_done) state <= S_GC_STEP;
                S_GC_ERS: if (nand_done) begin
                    free_mask[victim_q] <= 1'b1;
                    state               <= S_IDLE;
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    AST_ONE_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        nand_cmd_valid |=> !nand_cmd_valid); // R10
    AST_UNMAPPED_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && $past(state == S_IDLE)) |-> (&rsp_data)); // R4
    AST_ERASE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (nand_cmd_valid && nand_op == NOP_ERASE) |-> (vic_cnt == '0)); // R7
    AST_VICTIM_FOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_GC_SCAN) |-> victim_ok); // R6
    AST_ALLOC_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_done && act_pg == LAST_PG) |-> (free_mask != '0)); // R8
    AST_WA_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        phys_wr_cnt >= host_wr_cnt); // R9
endmodule

// File: tb/tb_ftl_top.sv
// Scoreboard bench: driver tasks queue expected read data, a monitor pops and
// compares on each response, and a flash model checks every NAND command.
module tb_ftl_top;
    localparam int BLOCKS = 8, PAGES = 4, LPAGES = 16, DATA_W = 8, CNT_W = 16;
    localparam int NPPA = BLOCKS * PAGES, PPA_W = 5, LPA_W = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic              host_valid = 1'b0;
    logic [1:0]        host_op = '0;
    logic [LPA_W-1:0]  host_lpa = '0;
    logic [DATA_W-1:0] host_wdata = '0;
    logic              host_ready, rsp_valid, nand_cmd_valid;
    logic [DATA_W-1:0] rsp_data, nand_wdata;
    logic [1:0]        nand_op;
    logic [PPA_W-1:0]  nand_ppa;
    logic              nand_done = 1'b0;
    logic [DATA_W-1:0] nand_rdata = '0;
    logic [CNT_W-1:0]  host_wr_cnt, phys_wr_cnt;

    ftl_top #(.BLOCKS(BLOCKS), .PAGES(PAGES), .LPAGES(LPAGES), .DATA_W(DATA_W),
              .GC_THRESH(2), .CNT_W(CNT_W)) dut (
        .clk(clk), .rst_n(rst_n), .host_valid(host_valid), .host_op(host_op),
        .host_lpa(host_lpa), .host_wdata(host_wdata), .host_ready(host_ready),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .nand_cmd_valid(nand_cmd_valid),
        .nand_op(nand_op), .nand_ppa(nand_ppa), .nand_wdata(nand_wdata),
        .nand_done(nand_done), .nand_rdata(nand_rdata),
        .host_wr_cnt(host_wr_cnt), .phys_wr_cnt(phys_wr_cnt)
    );

    int checks = 0, fails = 0;
    task automatic check(bit ok, string req, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Flash model: two-cycle completion, erase-before-program enforced.
    logic [DATA_W-1:0] fmem [NPPA];
    bit                fprog [NPPA];
    int busy = 0, prog_cnt = 0, read_cnt = 0, erase_cnt = 0;
    int last_prog_ppa = -1, last_erase_blk = -1;
    always @(negedge clk) begin
        nand_done = 1'b0;
        if (busy > 0) begin
            busy--;
            if (busy == 0) nand_done = 1'b1;
        end
        if (rst_n && nand_cmd_valid) begin
            if (busy != 0) check(1'b0, "R10", "command while busy", busy, 0);
            case (nand_op)
                2'd0: begin
                    if (!fprog[nand_ppa]) check(1'b0, "R7", "read of erased page", nand_ppa, -1);
                    nand_rdata = fmem[nand_ppa];
                    read_cnt++;
                end
                2'd1: begin
                    if (fprog[nand_ppa]) check(1'b0, "R2", "program of used page", nand_ppa, -1);
                    fmem[nand_ppa]  = nand_wdata;
                    fprog[nand_ppa] = 1'b1;
                    prog_cnt++;
                    last_prog_ppa = int'(nand_ppa);
                end
                default: begin
                    if (nand_ppa % PAGES != 0) check(1'b0, "R10", "erase page bits", nand_ppa % PAGES, 0);
                    for (int p = 0; p < PAGES; p++) fprog[int'(nand_ppa) - int'(nand_ppa) % PAGES + p] = 1'b0;
                    erase_cnt++;
                    last_erase_blk = int'(nand_ppa) / PAGES;
                end
            endcase
            busy = 2;
        end
    end

    // Monitor: pop the expected value for each read response.
    logic [DATA_W-1:0] exp_q [$];
    logic [DATA_W-1:0] exp_v;
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R1", "unexpected response", rsp_data, 0);
            end else begin
                exp_v = exp_q.pop_front();
                check(rsp_data == exp_v, "R1", "read data", rsp_data, exp_v);
            end
        end
    end

    // Reference model of the logical space.
    logic [DATA_W-1:0] model [LPAGES];
    bit mapped [LPAGES];
    bit had [LPAGES];
    int host_ppa [LPAGES];
    int host_writes = 0;

    task automatic tick();
        @(negedge clk);
        #1;
    endtask

    task automatic issue(logic [1:0] op, int lpa, logic [DATA_W-1:0] d);
        while (!host_ready) tick();
        host_valid = 1'b1;
        host_op    = op;
        host_lpa   = LPA_W'(lpa);
        host_wdata = d;
        tick();
        host_valid = 1'b0;
    endtask

    task automatic do_write(int lpa, logic [DATA_W-1:0] d);
        int pc = prog_cnt;
        issue(2'd1, lpa, d);
        while (prog_cnt == pc) tick();
        if (had[lpa]) check(last_prog_ppa != host_ppa[lpa], "R2", "rewrite location", last_prog_ppa, -1);
        host_ppa[lpa] = last_prog_ppa;
        had[lpa]      = 1'b1;
        model[lpa]    = d;
        mapped[lpa]   = 1'b1;
        host_writes++;
    endtask

    task automatic do_read(int lpa);
        int rc = read_cnt;
        bit was_mapped = mapped[lpa];
        exp_q.push_back(was_mapped ? model[lpa] : '1);
        issue(2'd0, lpa, '0);
        while (exp_q.size() != 0) tick();
        if (!was_mapped) check(read_cnt == rc, "R4", "flash read on unmapped page", read_cnt - rc, 0);
    endtask

    task automatic do_trim(int lpa);
        issue(2'd2, lpa, '0);
        mapped[lpa] = 1'b0;
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL R10 watchdog expired: actual 1 expected 0");
        finish_run();
    end

    initial begin
        for (int i = 0; i < LPAGES; i++) begin
            mapped[i] = 1'b0;
            had[i]    = 1'b0;
        end
        for (int i = 0; i < NPPA; i++) fprog[i] = 1'b0;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R11: reset state
        check(host_ready == 1'b1, "R11", "ready after reset", host_ready, 1);
        check(host_wr_cnt == 0 && phys_wr_cnt == 0, "R11", "counters after reset", host_wr_cnt + phys_wr_cnt, 0);
        check(nand_cmd_valid == 1'b0, "R11", "no command after reset", nand_cmd_valid, 0);
        // R4: never-written page
        do_read(3);
        // R8: first page of block 0
        do_write(0, 8'h10);
        check(last_prog_ppa == 0, "R8", "first program address", last_prog_ppa, 0);
        for (int i = 1; i < 4; i++) do_write(i, 8'h10 + 8'(i));
        do_write(4, 8'h24);
        check(last_prog_ppa == 4, "R8", "second block start", last_prog_ppa, 4);
        for (int i = 5; i < 8; i++) do_write(i, 8'h20 + 8'(i));
        do_read(1);
        // Block 0 becomes fully superseded, block 1 half.
        for (int i = 0; i < 4; i++) do_write(i, 8'h30 + 8'(i));
        do_write(1, 8'h31);
        for (int i = 8; i < 12; i++) do_write(i, 8'h40 + 8'(i));
        // The extra rewrite of lpa 1 took one page; fill up to the fifth block end.
        do_write(4, 8'h54);
        do_write(5, 8'h55);
        do_write(12, 8'h5c);
        while (!host_ready) tick();
        // R3, R6: victim is the all-dead block 0, nothing copied
        check(erase_cnt == 1, "R6", "erase count after first collection", erase_cnt, 1);
        check(last_erase_blk == 0, "R6", "first victim block", last_erase_blk, 0);
        check(phys_wr_cnt == host_wr_cnt, "R3", "copies from dead block", phys_wr_cnt - host_wr_cnt, 0);
        check(host_wr_cnt == 20, "R9", "host writes", host_wr_cnt, 20);
        // R5: trim lpa 6, read it back as ones
        do_trim(6);
        do_read(6);
        do_write(13, 8'h6d);
        check(last_prog_ppa == 20, "R8", "sixth block start", last_prog_ppa, 20);
        do_write(14, 8'h6e);
        do_write(15, 8'h6f);
        do_write(0, 8'h70);
        while (!host_ready) tick();
        // Block 1 holds only lpa 7 live: one copy into freed block 0.
        check(erase_cnt == 2, "R6", "erase count after second collection", erase_cnt, 2);
        check(last_erase_blk == 1, "R6", "second victim block", last_erase_blk, 1);
        check(phys_wr_cnt == host_wr_cnt + 1, "R5", "copies after trim", phys_wr_cnt - host_wr_cnt, 1);
        check(last_prog_ppa == 0, "R8", "copy lands in lowest free block", last_prog_ppa, 0);
        do_read(7);   // R7: relocated data preserved
        do_read(6);
        do_read(2);
        // R1: ignored opcode 3 changes nothing
        issue(2'd3, 2, 8'h00);
        do_read(2);
        // Random mix driving many collections.
        for (int n = 0; n < 400; n++) begin
            int r   = $urandom_range(0, 9);
            int lpa = $urandom_range(0, LPAGES - 1);
            if (r < 6)      do_write(lpa, 8'($urandom_range(0, 255)));
            else if (r < 9) do_read(lpa);
            else            do_trim(lpa);
        end
        for (int i = 0; i < LPAGES; i++) do_read(i);
        while (!host_ready) tick();
        check(host_wr_cnt == CNT_W'(host_writes), "R9", "host write count", host_wr_cnt, host_writes);
        check(phys_wr_cnt == CNT_W'(prog_cnt), "R9", "physical write count", phys_wr_cnt, prog_cnt);
        check(erase_cnt > 2, "R6", "collections during random mix", erase_cnt, 3);
        finish_run();
    end
endmodule